// File: doc/BRIEF.md
# Software Interrupt Request Register with Level Masking

This block keeps a 17-bit register of software interrupt requests and turns it into a vector of pending requests. Each pending bit is gated by a 4-bit processor interrupt level. Software reaches the register through one write port that has four operations. It can load the whole register, OR bits into it, clear bits with a mask, or load a new interrupt level. Two timer match inputs let hardware set the two timer bits directly: bit 0 for the cycle timer and bit 16 for the system timer.

Bits 1 to 15 are each compared with the current level, and a bit is pending only when its index is strictly above the level. The two timer bits ignore their index and use a fixed threshold instead: they are pending only while the level is below 14. The pending vector is registered and is computed again on every clock from the current register contents and level. Any change to either one therefore shows up on the outputs one cycle later. Both the register and the level can be read back on dedicated outputs. Turning the pending vector into a trap number is left to the logic downstream.

Top module: `sirq_unit`

## Requirements
- R1: While `rst_n` is low, the register, the level and the pending vector are all zero, and they stay zero for the first cycle after release.
- R2: A write with `wr_op`=0 loads `wr_data[16:0]` into the register. Data bits 17 and above have no effect, and `bits_o` always shows them as zero.
- R3: A write with `wr_op`=1 ORs `wr_data[16:0]` into the register.
- R4: A write with `wr_op`=2 clears every register bit whose position is set in `wr_data[16:0]` and keeps every other bit.
- R5: For n from 1 to 15, `pend_o[n]` is 1 exactly when register bit n was set and n was strictly greater than the level, both taken one cycle earlier.
- R6: `pend_o[0]` and `pend_o[16]` are 1 exactly when the matching register bit was set and the level was below 14, both taken one cycle earlier.
- R7: A write with `wr_op`=3 loads `wr_data[3:0]` into the level and leaves the register unchanged. The pending vector is computed against the new level on the next cycle.
- R8: `pend_o` follows changes of the register or the level exactly one clock later.
- R9: `tick_match` sets register bit 0 and `stick_match` sets register bit 16, and the same masking applies to them as to bits written by software. When one of these inputs is high in the same cycle as a write, the write is applied first and the hardware set second, so a clear does not cancel a match in that cycle.
- R10: When `wr_en` is low and both match inputs are low, the register and the level keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_op | input | 2 | 0 load, 1 set bits, 2 clear bits, 3 load level |
| wr_data | input | 32 | Write data |
| tick_match | input | 1 | Cycle timer match, sets bit 0 |
| stick_match | input | 1 | System timer match, sets bit 16 |
| bits_o | output | 17 | Register read-back |
| level_o | output | 4 | Interrupt level read-back |
| pend_o | output | 17 | Registered pending requests |

## Verification
The bench builds the block with its default parameters: 32-bit write data, a 4-bit level, 17 request bits and a timer threshold of 14. With a 4-bit level, every level value from 0 to 15 can be reached. That covers the threshold edges at 13, 14 and 15, and a level of 15 masks every indexed bit. With 32-bit data, the bench can also drive ones into bits 17 to 31, which the block must discard. Random operations run with the match inputs mixed in against a cycle-exact model, and directed cases cover the clear-then-set ordering.

// File: rtl/sirq_pkg.sv
// Package: shared operation encoding for the software interrupt register.
// Assumes the write port carries a 2-bit operation code.
package sirq_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2,
        OP_LEVEL = 2'd3
    } sirq_op_e;
endpackage

// File: rtl/sirq_store.sv
// sirq_store: holds the request bits and the interrupt level.
// It applies one software operation per cycle, then ORs in the hardware set bits.
// Assumes DATA_W >= NBITS and DATA_W >= LVL_W.
module sirq_store #(
    parameter int NBITS  = 17,
    parameter int DATA_W = 32,
    parameter int LVL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_op,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NBITS-1:0]  hw_set,
    output logic [NBITS-1:0]  bits_q,
    output logic [LVL_W-1:0]  lvl_q
);
    import sirq_pkg::*;

    logic [NBITS-1:0] wdat;
    logic [NBITS-1:0] after_wr;
    logic [NBITS-1:0] bits_d;
    logic [LVL_W-1:0] lvl_d;

    assign wdat = wr_data[NBITS-1:0];

    // Next-state: apply the software operation first, then the hardware set.
    always_comb begin
        after_wr = bits_q;
        lvl_d    = lvl_q;
        if (wr_en) begin
            case (sirq_op_e'(wr_op))
                OP_LOAD:  after_wr = wdat;
                OP_SET:   after_wr = bits_q | wdat;
                OP_CLR:   after_wr = bits_q & ~wdat;
                OP_LEVEL: lvl_d    = wr_data[LVL_W-1:0];
                default:  after_wr = bits_q;
            endcase
        end
        bits_d = after_wr | hw_set;
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
            lvl_q  <= '0;
        end else begin
            bits_q <= bits_d;
            lvl_q  <= lvl_d;
        end
    end
endmodule

// File: rtl/sirq_mask.sv
// sirq_mask: compares each request bit with the interrupt level and registers the result.
// The lowest and highest bits are timer bits and use a fixed threshold.
// Every bit in between uses its own index as its threshold.
// Assumes NBITS >= 3.
module sirq_mask #(
    parameter int NBITS     = 17,
    parameter int LVL_W     = 4,
    parameter int TIMER_LVL = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] bits_q,
    input  logic [LVL_W-1:0] lvl_q,
    output logic [NBITS-1:0] pend_q
);
    localparam logic [31:0] TIMER_THR = TIMER_LVL;

    logic [31:0]      lvl_ext;
    logic             timer_open;
    logic [NBITS-1:0] pend_d;

    assign lvl_ext    = {{(32-LVL_W){1'b0}}, lvl_q};
    assign timer_open = lvl_ext < TIMER_THR;

    // Per-bit gate: the timer bits use the threshold, the other bits compare their index.
    for (genvar i = 0; i < NBITS; i++) begin : g_gate
        if (i == 0 || i == NBITS-1) begin : g_timer
            assign pend_d[i] = bits_q[i] & timer_open;
        end else begin : g_index
            localparam logic [31:0] IDX = i;
            assign pend_d[i] = bits_q[i] & (IDX > lvl_ext);
        end
    end

    // Pending register, updated every cycle from the current register and level.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end
endmodule

// File: rtl/sirq_unit.sv
// sirq_unit: top of the software interrupt register.
// It maps the two timer match inputs onto the end bits, then chains the store and the mask stages.
// Assumes a single clock domain and a synchronous active-low reset.
module sirq_unit #(
    parameter int NBITS     = 17,
    parameter int DATA_W    = 32,
    parameter int LVL_W     = 4,
    parameter int TIMER_LVL = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_op,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tick_match,
    input  logic              stick_match,
    output logic [NBITS-1:0]  bits_o,
    output logic [LVL_W-1:0]  level_o,
    output logic [NBITS-1:0]  pend_o
);
    logic [NBITS-1:0] hw_set;

    // Route the timer matches onto the low and high request bits.
    always_comb begin
        hw_set          = '0;
        hw_set[0]       = tick_match;
        hw_set[NBITS-1] = stick_match;
    end

    sirq_store #(.NBITS(NBITS), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op),
        .wr_data(wr_data), .hw_set(hw_set), .bits_q(bits_o), .lvl_q(level_o)
    );

    sirq_mask #(.NBITS(NBITS), .LVL_W(LVL_W), .TIMER_LVL(TIMER_LVL)) u_mask (
        .clk(clk), .rst_n(rst_n), .bits_q(bits_o), .lvl_q(level_o), .pend_q(pend_o)
    );
endmodule

// File: rtl/sirq_unit_chk.sv
// sirq_unit_chk: temporal checks on the top-level ports of sirq_unit.
// It is attached to the top module by the bind statement at the end of this file.
module sirq_unit_chk #(
    parameter int NBITS     = 17,
    parameter int DATA_W    = 32,
    parameter int LVL_W     = 4,
    parameter int TIMER_LVL = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_op,
    input logic [DATA_W-1:0] wr_data,
    input logic              tick_match,
    input logic              stick_match,
    input logic [NBITS-1:0]  bits_o,
    input logic [LVL_W-1:0]  level_o,
    input logic [NBITS-1:0]  pend_o
);
    localparam logic [LVL_W-1:0] TL = LVL_W'(TIMER_LVL);

    a_r3_set_ors: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == 2'd1) |=> ((bits_o & $past(wr_data[NBITS-1:0])) == $past(wr_data[NBITS-1:0])));

    a_r4_clear_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == 2'd2 && !tick_match && !stick_match) |=> ((bits_o & $past(wr_data[NBITS-1:0])) == '0));

    a_r5_pend_subset: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_o & ~$past(bits_o)) == '0));

    a_r6_timer_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o >= TL) |=> (!pend_o[0] && !pend_o[NBITS-1]));

    a_r7_level_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == 2'd3 && !tick_match && !stick_match) |=> $stable(bits_o));

    a_r9_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_match || stick_match) |=> ((!$past(tick_match) || bits_o[0]) && (!$past(stick_match) || bits_o[NBITS-1])));

    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !tick_match && !stick_match) |=> ($stable(bits_o) && $stable(level_o)));
endmodule

bind sirq_unit sirq_unit_chk #(.NBITS(NBITS), .DATA_W(DATA_W), .LVL_W(LVL_W), .TIMER_LVL(TIMER_LVL)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op), .wr_data(wr_data),
    .tick_match(tick_match), .stick_match(stick_match),
    .bits_o(bits_o), .level_o(level_o), .pend_o(pend_o)
);

// File: tb/tb_sirq_unit.sv
`timescale 1ns/1ps
module tb_sirq_unit;
    localparam int NB = 17;
    localparam int DW = 32;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_op = 2'd0;
    logic [DW-1:0] wr_data = '0;
    logic          tick_match = 1'b0;
    logic          stick_match = 1'b0;
    logic [NB-1:0] bits_o;
    logic [LW-1:0] level_o;
    logic [NB-1:0] pend_o;

    int n_vec = 0;
    int n_bad = 0;
    logic [NB-1:0] m_bits = '0;
    logic [LW-1:0] m_lvl  = '0;
    logic [NB-1:0] m_pend = '0;

    sirq_unit dut (.*);

    always #2.5 clk = ~clk;

    // Reference gate: timer bits open below level 14, other bits when index > level.
    function automatic logic [NB-1:0] exp_pend(input logic [NB-1:0] b, input logic [LW-1:0] l);
        logic [NB-1:0] r;
        for (int i = 0; i < NB; i++) begin
            if (i == 0 || i == NB-1) r[i] = b[i] && (int'(l) < 14);
            else                     r[i] = b[i] && (i > int'(l));
        end
        return r;
    endfunction

    // Reference next register value: the write first, then the match inputs.
    function automatic logic [NB-1:0] exp_bits(input logic [NB-1:0] b, input logic en,
                                               input logic [1:0] op, input logic [DW-1:0] d,
                                               input logic tm, input logic sm);
        logic [NB-1:0] r = b;
        if (en) begin
            case (op)
                2'd0: r = d[NB-1:0];
                2'd1: r = b | d[NB-1:0];
                2'd2: r = b & ~d[NB-1:0];
                default: r = b;
            endcase
        end
        r[0]    = r[0] | tm;
        r[NB-1] = r[NB-1] | sm;
        return r;
    endfunction

    task automatic check(input string req);
        n_vec++;
        if (bits_o !== m_bits || level_o !== m_lvl || pend_o !== m_pend) begin
            n_bad++;
            $display("FAIL %s: bits=%h lvl=%0d pend=%h expected bits=%h lvl=%0d pend=%h",
                     req, bits_o, level_o, pend_o, m_bits, m_lvl, m_pend);
        end
    endtask

    // Drive one cycle at the falling edge, advance the model, then check at the next falling edge.
    task automatic step(input logic en, input logic [1:0] op, input logic [DW-1:0] d,
                        input logic tm, input logic sm, input string req);
        wr_en = en; wr_op = op; wr_data = d; tick_match = tm; stick_match = sm;
        m_pend = exp_pend(m_bits, m_lvl);
        m_bits = exp_bits(m_bits, en, op, d, tm, sm);
        if (en && op == 2'd3) m_lvl = d[LW-1:0];
        @(negedge clk);
        check(req);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release");

        step(1, 2'd0, 32'hFFFE_0002, 0, 0, "R2 load ignores upper bits");
        step(0, 2'd0, 0, 0, 0, "R8 pend one cycle later");
        step(1, 2'd1, 32'h0000_0300, 0, 0, "R3 set");
        step(1, 2'd2, 32'h0000_0102, 0, 0, "R4 clear");
        step(1, 2'd0, 32'h0001_FFFF, 0, 0, "R2 load all");
        step(1, 2'd3, 32'd13, 0, 0, "R7 level 13");
        step(0, 2'd0, 0, 0, 0, "R6 level 13 timers open");
        step(1, 2'd3, 32'd14, 0, 0, "R7 level 14");
        step(0, 2'd0, 0, 0, 0, "R6 level 14 timers masked");
        step(1, 2'd3, 32'd15, 0, 0, "R7 level 15");
        step(0, 2'd0, 0, 0, 0, "R5 level 15 masks all");
        step(1, 2'd3, 32'd0, 0, 0, "R7 level 0");
        step(1, 2'd0, 32'h0, 0, 0, "R2 load zero");
        step(1, 2'd2, 32'h0001_0001, 1, 1, "R9 clear then match");
        step(0, 2'd0, 0, 0, 0, "R9 match pending");
        step(0, 2'd0, 0, 0, 0, "R10 idle hold");

        for (int k = 0; k < 3000; k++) begin
            logic [1:0] op;
            logic [DW-1:0] d;
            op = 2'($urandom_range(0, 3));
            d  = $urandom;
            if (op == 2'd3) d = DW'($urandom_range(0, 15));
            step(1'($urandom_range(0, 1)), op, d,
                 ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0),
                 "R5 R6 R8 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #150000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule